// File: doc/BRIEF.md
# DMA Burst Splitter and Completion Tracker

This block takes one DMA command at a time. A command carries a start address, a byte length, a direction and a completion delay. The block cuts the transfer into memory requests, and no request crosses a block boundary. Each request carries the memory address, its size in bytes and its byte offset within the transfer. The requests wait in a small in-order queue and leave through a valid/ready request port.

When the memory side refuses a request, the port goes quiet until a retry strobe arrives. It then offers the same request again.

Responses are assumed to return in request order. The block credits each response with the size that was asked for. When the credited total reaches the command length, it waits the programmed delay plus the latency reported with the final response, then emits a one-cycle completion pulse. A drain handshake tells the caller whether requests are still outstanding. If they are, it signals once when they have all been answered.

Top module: `dma_split_track`

## Requirements
- R1: A piece never spans a boundary of BLK_BYTES (a power of two). The first piece of a transfer ends at the next boundary or at the end of the transfer, whichever comes first. Every later piece is at most BLK_BYTES. req_addr equals cmd_addr plus req_offset.
- R2: req_offset is the sum of the sizes of all earlier pieces of the same transfer. The first piece has offset 0.
- R3: Pieces appear on the request port strictly in address order. A piece leaves only on a cycle with req_valid and req_ready both high. Every piece of the transfer is issued before completion.
- R4: After a cycle with req_valid high and req_ready low, req_valid stays low until the cycle after a retry strobe. The block then offers the same piece again.
- R5: A command is accepted on a cycle with cmd_valid and cmd_ready high. On acceptance the outstanding count rises by the number of pieces in the transfer. Each response lowers it by one. A response while the count is zero raises rsp_err in that same cycle and changes nothing else.
- R6: Each response credits the size that was requested for the oldest unanswered piece. The transfer is complete on the response that brings the credited total to cmd_len.
- R7: Let the final response arrive in cycle c, and let S be cmd_delay plus the rsp_lat of that final response. Then done is high in cycle c+1+S, so it fires in the next cycle when S is zero.
- R8: done is a one-cycle pulse. cmd_ready is low from the cycle after acceptance up to and including the done cycle, and is high again in the cycle that follows.
- R9: drain_idle is high in the same cycle as drain_req whenever the outstanding count is zero.
- R10: A drain_req seen while requests are outstanding is latched. drain_done is then high for exactly one cycle, when the outstanding count is next zero, and the latch clears.
- R11: A synchronous active-high reset leaves cmd_ready high and req_valid, done, rsp_err, drain_idle and drain_done low, with every counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_addr | input | 32 | Transfer start address |
| cmd_len | input | 16 | Transfer length in bytes, nonzero |
| cmd_write | input | 1 | Direction, 1 = write |
| cmd_delay | input | 8 | Programmed completion delay in cycles |
| req_valid | output | 1 | Head piece offered |
| req_ready | input | 1 | Memory side takes the piece |
| req_addr | output | 32 | Piece address |
| req_size | output | 16 | Piece size in bytes |
| req_offset | output | 16 | Piece offset inside the transfer |
| req_write | output | 1 | Piece direction |
| retry | input | 1 | Memory side can take the refused piece again |
| rsp_valid | input | 1 | One response arrives |
| rsp_lat | input | 8 | Extra latency reported with the response |
| rsp_err | output | 1 | Response arrived with nothing outstanding |
| done | output | 1 | Completion pulse |
| drain_req | input | 1 | Drain request strobe |
| drain_idle | output | 1 | Drain answered immediately, nothing outstanding |
| drain_done | output | 1 | Latched drain finished |

## Verification
The bench walks transfers that start mid-block, exactly on a boundary, one byte before a boundary, and with a single byte. An off-by-one in the boundary arithmetic would show up here as a piece that runs over the boundary or leaves a gap.

Refusal windows are spaced so that refusals land on first, middle and last pieces. A design that kept req_valid high, or that moved to the next piece after a refusal, would duplicate or lose a piece in the compared sequence.

Completion is timed with a zero total delay, a delay made only of response latency, and a mix of the two. An error in the countdown would move the done pulse by a cycle.

A stray response while idle, a drain request while idle and a drain request in mid-transfer target the outstanding counter. An underflow, or a drain_done that repeats, would show up as an unexpected pulse.

// File: rtl/dma_st_pkg.sv
package dma_st_pkg;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int DLY_W  = 8;

    // one accepted command
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              wr;
        logic [DLY_W-1:0]  dly;
    } xfer_t;

    // one queued memory request
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  size;
        logic [LEN_W-1:0]  off;
        logic              wr;
    } piece_t;

    // bytes up to the next boundary, capped by what is left
    function automatic logic [LEN_W-1:0] piece_len(
        input logic [ADDR_W-1:0] a,
        input logic [LEN_W-1:0]  left,
        input int unsigned       blk
    );
        logic [LEN_W:0] room;
        room = (LEN_W+1)'(blk) - (LEN_W+1)'(a & ADDR_W'(blk - 1));
        return ({1'b0, left} < room) ? left : room[LEN_W-1:0];
    endfunction

    // number of boundary-limited pieces in a transfer
    function automatic logic [LEN_W:0] piece_count(
        input logic [ADDR_W-1:0] a,
        input logic [LEN_W-1:0]  len,
        input int unsigned       blk_lg
    );
        logic [LEN_W+1:0] span;
        span = (LEN_W+2)'(a & ADDR_W'((1 << blk_lg) - 1))
             + (LEN_W+2)'(len)
             + (LEN_W+2)'((1 << blk_lg) - 1);
        return (LEN_W+1)'(span >> blk_lg);
    endfunction

endpackage

// File: rtl/dma_st_splitter.sv
module dma_st_splitter
    import dma_st_pkg::*;
#(
    parameter int BLK_BYTES = 64
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  xfer_t  xfer,
    input  logic   fifo_full,
    output logic   push,
    output piece_t piece
);

    logic             active;
    logic [LEN_W-1:0] off;

    always_comb begin
        piece.addr = xfer.addr + ADDR_W'(off);
        piece.off  = off;
        piece.wr   = xfer.wr;
        piece.size = piece_len(piece.addr, xfer.len - off, BLK_BYTES);
        push       = active && !fifo_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            off    <= '0;
        end else if (start) begin
            active <= 1'b1;
            off    <= '0;
        end else if (push) begin
            off <= off + piece.size;
            if (off + piece.size == xfer.len)
                active <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_st_fifo.sv
module dma_st_fifo
    import dma_st_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  piece_t din,
    input  logic   pop,
    output piece_t dout,
    output logic   empty,
    output logic   full
);

    localparam int PW = $clog2(DEPTH);

    piece_t        mem [DEPTH];
    logic [PW:0]   wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
    assign dout  = mem[rp[PW-1:0]];

    always_ff @(posedge clk) begin
        if (push)
            mem[wp[PW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

endmodule

// File: rtl/dma_st_tracker.sv
module dma_st_tracker
    import dma_st_pkg::*;
#(
    parameter int BLK_BYTES = 64,
    parameter int LAT_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W:0]   n_pieces,
    input  xfer_t            xfer,
    input  logic             rsp_valid,
    input  logic [LAT_W-1:0] rsp_lat,
    input  logic             drain_req,
    output logic             done,
    output logic             rsp_err,
    output logic             drain_idle,
    output logic             drain_done,
    output logic [LEN_W:0]   outst,
    output logic [LEN_W-1:0] rcv
);

    localparam int TMR_W = ((DLY_W > LAT_W) ? DLY_W : LAT_W) + 1;

    logic             rsp_take, last;
    logic [LEN_W-1:0] rsz;
    logic [TMR_W-1:0] sum, tmr;
    logic             dpend;

    always_comb begin
        rsp_take   = rsp_valid && (outst != '0);
        rsp_err    = rsp_valid && (outst == '0);
        rsz        = piece_len(xfer.addr + ADDR_W'(rcv), xfer.len - rcv, BLK_BYTES);
        last       = rsp_take && (rcv + rsz == xfer.len);
        sum        = TMR_W'(xfer.dly) + TMR_W'(rsp_lat);
        drain_idle = drain_req && (outst == '0);
        drain_done = dpend && (outst == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            outst <= '0;
            rcv   <= '0;
            tmr   <= '0;
            done  <= 1'b0;
            dpend <= 1'b0;
        end else begin
            done  <= 1'b0;
            dpend <= (outst != '0) && (dpend || drain_req);
            if (start) begin
                outst <= outst + n_pieces;
                rcv   <= '0;
            end else if (rsp_take) begin
                outst <= outst - 1'b1;
                rcv   <= rcv + rsz;
            end
            if (last) begin
                if (sum == '0) done <= 1'b1;
                else           tmr  <= sum;
            end else if (tmr != '0) begin
                tmr <= tmr - 1'b1;
                if (tmr == TMR_W'(1))
                    done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_split_track.sv
module dma_split_track
    import dma_st_pkg::*;
#(
    parameter int BLK_BYTES  = 64,
    parameter int FIFO_DEPTH = 4,
    parameter int LAT_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_write,
    input  logic [DLY_W-1:0]  cmd_delay,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_size,
    output logic [LEN_W-1:0]  req_offset,
    output logic              req_write,
    input  logic              retry,
    input  logic              rsp_valid,
    input  logic [LAT_W-1:0]  rsp_lat,
    output logic              rsp_err,
    output logic              done,
    input  logic              drain_req,
    output logic              drain_idle,
    output logic              drain_done
);

    localparam int BLK_LG = $clog2(BLK_BYTES);

    xfer_t            cmd_q, cmd_in;
    logic             busy, start, wait_q;
    logic             push, fifo_empty, fifo_full;
    piece_t           piece_in, head;
    logic [LEN_W:0]   outst;
    logic [LEN_W-1:0] rcv;

    assign cmd_in    = '{addr: cmd_addr, len: cmd_len, wr: cmd_write, dly: cmd_delay};
    assign cmd_ready = !busy;
    assign start     = cmd_valid && !busy;

    assign req_valid  = !fifo_empty && !wait_q;
    assign req_addr   = head.addr;
    assign req_size   = head.size;
    assign req_offset = head.off;
    assign req_write  = head.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cmd_q  <= '0;
            wait_q <= 1'b0;
        end else begin
            if (start)     busy <= 1'b1;
            else if (done) busy <= 1'b0;
            if (start)     cmd_q <= cmd_in;
            if (wait_q)    wait_q <= !retry;
            else           wait_q <= req_valid && !req_ready;
        end
    end

    dma_st_splitter #(.BLK_BYTES(BLK_BYTES)) u_split (
        .clk(clk), .rst(rst), .start(start), .xfer(cmd_q),
        .fifo_full(fifo_full), .push(push), .piece(piece_in)
    );

    dma_st_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .din(piece_in),
        .pop(req_valid && req_ready), .dout(head),
        .empty(fifo_empty), .full(fifo_full)
    );

    dma_st_tracker #(.BLK_BYTES(BLK_BYTES), .LAT_W(LAT_W)) u_track (
        .clk(clk), .rst(rst), .start(start),
        .n_pieces(piece_count(cmd_addr, cmd_len, BLK_LG)),
        .xfer(cmd_q), .rsp_valid(rsp_valid), .rsp_lat(rsp_lat),
        .drain_req(drain_req), .done(done), .rsp_err(rsp_err),
        .drain_idle(drain_idle), .drain_done(drain_done),
        .outst(outst), .rcv(rcv)
    );

endmodule

// File: rtl/dma_st_chk.sv
module dma_st_chk
    import dma_st_pkg::*;
#(
    parameter int BLK_BYTES = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LEN_W-1:0]  req_size,
    input logic              done,
    input logic              drain_done,
    input logic [LEN_W:0]    outst,
    input logic [LEN_W-1:0]  rcv,
    input logic [LEN_W-1:0]  len
);

    // R1
    piece_in_block_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_size != '0) &&
        ((LEN_W+1)'(req_addr & ADDR_W'(BLK_BYTES - 1)) + (LEN_W+1)'(req_size)
            <= (LEN_W+1)'(BLK_BYTES)));

    // R4
    refused_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> !req_valid);

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (outst == '0 && !(cmd_valid && cmd_ready)) |=> (outst == '0));

    // R6
    credit_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rcv <= len);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !cmd_ready);

    // R10
    drain_once_chk: assert property (@(posedge clk) disable iff (rst)
        drain_done |=> !drain_done);

endmodule

bind dma_split_track dma_st_chk #(.BLK_BYTES(BLK_BYTES)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .done(done), .drain_done(drain_done),
    .outst(outst), .rcv(rcv), .len(cmd_q.len)
);

// File: tb/dma_split_track_test.sv
`timescale 1ns/100ps
module dma_split_track_test;
    import dma_st_pkg::*;

    localparam int BLK = 64;
    localparam int RL  = 3;

    logic clk = 0, rst = 1;
    logic cmd_valid = 0, cmd_ready, cmd_write = 0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic [DLY_W-1:0]  cmd_delay = '0;
    logic req_valid, req_ready = 1, req_write, retry = 0;
    logic [ADDR_W-1:0] req_addr;
    logic [LEN_W-1:0]  req_size, req_offset;
    logic rsp_valid = 0, rsp_err, done, drain_req = 0, drain_idle, drain_done;
    logic [7:0] rsp_lat = '0;

    always #2 clk = ~clk;

    dma_split_track uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_write(cmd_write),
        .cmd_delay(cmd_delay), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_offset(req_offset),
        .req_write(req_write), .retry(retry), .rsp_valid(rsp_valid),
        .rsp_lat(rsp_lat), .rsp_err(rsp_err), .done(done),
        .drain_req(drain_req), .drain_idle(drain_idle), .drain_done(drain_done)
    );

    int errs = 0, checks = 0, cyc = 0;
    bit finished = 0, refuse = 0, inj = 0;

    typedef struct { longint a; int sz; int off; bit wr; } pc_t;
    pc_t exp_q[$];
    int  sz_q[$];
    int  rq[$];
    bit  m_busy, m_done, m_wait, m_dpend;
    int  m_outst, m_rcv, m_len, m_dly, m_cnt;

    bit s_cmd_valid, s_cmd_write, s_req_valid, s_req_ready, s_retry, s_rsp_valid, s_drain_req;
    longint s_cmd_addr;
    int s_cmd_len, s_cmd_delay, s_rsp_lat;

    task automatic chk(bit ok, string tag, longint act, longint expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
        end
    endtask

    // reference model: advances on every clock from the inputs snapshotted mid-cycle
    bit nd, ob;
    int o, off, sz, room, n, sum;
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_busy = 0; m_done = 0; m_wait = 0; m_dpend = 0;
            m_outst = 0; m_rcv = 0; m_len = 0; m_dly = 0; m_cnt = 0;
            exp_q.delete(); sz_q.delete(); rq.delete();
        end else begin
            o = m_outst; ob = m_busy; nd = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) nd = 1;
            end
            m_dpend = (o != 0) && (m_dpend || s_drain_req);
            if (m_done) m_busy = 0;
            if (s_cmd_valid && !ob) begin
                m_busy = 1; m_len = s_cmd_len; m_dly = s_cmd_delay; m_rcv = 0;
                off = 0; n = 0;
                while (off < s_cmd_len) begin
                    room = BLK - int'((s_cmd_addr + off) % BLK);
                    sz = (s_cmd_len - off < room) ? s_cmd_len - off : room;
                    exp_q.push_back('{a: (s_cmd_addr + off) & 64'hFFFF_FFFF, sz: sz, off: off, wr: s_cmd_write});
                    sz_q.push_back(sz);
                    off += sz; n++;
                end
                m_outst += n;
            end
            if (s_req_valid && s_req_ready) begin
                if (exp_q.size() > 0) void'(exp_q.pop_front());
                rq.push_back(cyc + RL);
            end
            if (s_req_valid && !s_req_ready) m_wait = 1;
            else if (m_wait && s_retry)      m_wait = 0;
            if (s_rsp_valid && o != 0) begin
                m_outst--;
                m_rcv += (sz_q.size() > 0) ? sz_q.pop_front() : 0;
                if (m_rcv == m_len) begin
                    sum = m_dly + s_rsp_lat;
                    if (sum == 0) nd = 1; else m_cnt = sum;
                end
            end
            m_done = nd;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(cmd_ready == !m_busy, "R8 cmd_ready", cmd_ready, !m_busy);
            chk(done == m_done, "R7 done timing", done, m_done);
            chk(drain_done == (m_dpend && m_outst == 0), "R10 drain_done", drain_done, m_dpend && m_outst == 0);
            if (m_wait) chk(!req_valid, "R4 quiet after refusal", req_valid, 0);
        end
        #0.5;
        s_cmd_valid = cmd_valid; s_cmd_addr = cmd_addr; s_cmd_len = cmd_len;
        s_cmd_write = cmd_write; s_cmd_delay = cmd_delay;
        s_req_valid = req_valid; s_req_ready = req_ready; s_retry = retry;
        s_rsp_valid = rsp_valid; s_rsp_lat = rsp_lat; s_drain_req = drain_req;
        if (!rst) begin
            chk(rsp_err == (s_rsp_valid && m_outst == 0), "R5 rsp_err", rsp_err, s_rsp_valid && m_outst == 0);
            chk(drain_idle == (s_drain_req && m_outst == 0), "R9 drain_idle", drain_idle, s_drain_req && m_outst == 0);
            if (req_valid) begin
                if (exp_q.size() == 0) chk(0, "R3 unexpected piece", req_addr, 0);
                else begin
                    chk(req_addr == exp_q[0].a, "R1 req_addr", req_addr, exp_q[0].a);
                    chk(req_size == exp_q[0].sz, "R1 req_size", req_size, exp_q[0].sz);
                    chk(req_offset == exp_q[0].off, "R2 req_offset", req_offset, exp_q[0].off);
                    chk(req_write == exp_q[0].wr, "R3 req_write", req_write, exp_q[0].wr);
                end
            end
        end
    end

    // in-order memory responder
    initial forever begin
        @(negedge clk);
        rsp_valid = inj;
        if (!inj && rq.size() > 0 && rq[0] <= cyc) begin
            rsp_valid = 1;
            void'(rq.pop_front());
        end
    end

    // refusal / retry pattern
    initial forever begin
        @(negedge clk);
        req_ready = !(refuse && (cyc % 4 == 1));
        retry     = refuse && (cyc % 4 == 3);
    end

    task automatic xfer(input longint a, input int len, input bit wr, input int dly,
                        input int lat, input bit ref_on, input int drain_at);
        int k;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        rsp_lat = 8'(lat); refuse = ref_on;
        cmd_valid = 1; cmd_addr = 32'(a); cmd_len = 16'(len); cmd_write = wr; cmd_delay = 8'(dly);
        @(negedge clk);
        cmd_valid = 0;
        k = 0;
        while (!done && k < 5000) begin
            if (k == drain_at) drain_req = 1;
            @(negedge clk);
            drain_req = 0;
            k++;
        end
        chk(done, "R7 completion reached", done, 1);
        chk(exp_q.size() == 0, "R3 all pieces issued", exp_q.size(), 0);
        chk(m_rcv == len, "R6 credited bytes", m_rcv, len);
        refuse = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(cmd_ready == 1, "R11 cmd_ready", cmd_ready, 1);
        chk(req_valid == 0, "R11 req_valid", req_valid, 0);
        chk(done == 0, "R11 done", done, 0);
        chk(drain_done == 0 && drain_idle == 0 && rsp_err == 0, "R11 flags", drain_done, 0);
        rst = 0;
        @(negedge clk);
        drain_req = 1;                       // R9 idle drain
        @(negedge clk);
        drain_req = 0;
        inj = 1;                             // R5 stray response
        @(negedge clk);
        inj = 0;
        repeat (3) @(negedge clk);
        chk(cmd_ready == 1 && done == 0, "R5 stray response ignored", cmd_ready, 1);
        xfer(64'h1030, 200, 1, 5, 0, 0, -1);   // R1 mid-block start
        xfer(64'h2000, 64, 0, 0, 0, 0, -1);    // R7 zero delay, aligned
        xfer(64'h3005, 300, 1, 0, 4, 1, -1);   // R4 refusals, latency only
        xfer(64'h4010, 150, 0, 2, 4, 0, 2);    // R10 drain mid-transfer
        xfer(64'h503F, 1, 1, 1, 0, 0, -1);     // single byte
        xfer(64'h607F, 2, 0, 0, 1, 1, 0);      // R1 crosses at last byte
        repeat (4) @(negedge clk);
        drain_req = 1;
        @(negedge clk);
        drain_req = 0;
        repeat (2) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule